// File: doc/BRIEF.md
# QoS Priority Arbiter with Least-Recently-Granted Tie-Break

This block chooses one of `NUM_PORTS` requesters each cycle. Every port presents a valid flag and a 4-bit priority that belongs to the transaction it is currently offering. The valid port with the numerically largest priority receives the grant. When several valid ports share that largest value, the port whose last completed grant lies furthest in the past wins. If every requester uses the same priority, the arbiter behaves as a pure least-recently-granted rotation.

The grant is a one-hot vector. The winner's priority and index are forwarded unchanged, so the priority travels downstream with the transaction. One shared downstream ready signal completes the handshake. While ready is low, the current grant is held even if a higher-priority request appears. The recency history changes only when a handshake completes.

Top module: `qos_lrg_arbiter`

## Requirements
- R1: Among valid ports, the grant goes to a port whose 4-bit priority is the numerically largest. Priority 0 is the lowest and 15 is the highest.
- R2: When two or more valid ports share the largest priority, the port among them that was granted least recently wins.
- R3: When all valid ports carry an equal priority, consecutive handshakes rotate through them in least-recently-granted order.
- R4: `out_prio_o` equals the priority of the granted port, and `out_port_o` equals its index.
- R5: `gnt_o` has exactly one bit set when any `req_valid_i` bit is high, and no bit set otherwise. `out_valid_o` is high exactly when a grant is given.
- R6: While the granted port stays valid and `out_ready_i` is low, the grant stays on that port in following cycles, even if a higher-priority request arrives.
- R7: The recency order changes only when a handshake completes (`out_valid_o` and `out_ready_i` both high). Completing a handshake moves the granted port to the most-recent end. A grant that is withdrawn before it is accepted leaves the order unchanged.
- R8: After reset, port 0 is the least recent and port `NUM_PORTS-1` the most recent.
- R9: A port's priority is taken per transaction. The same port may present a different priority for its next transaction, and the new value is used for arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | NUM_PORTS | Request valid, one bit per port |
| req_prio_i | input | NUM_PORTS*4 | Per-port priority; port p uses bits [4p+3:4p] |
| out_ready_i | input | 1 | Shared downstream ready |
| gnt_o | output | NUM_PORTS | One-hot grant |
| out_valid_o | output | 1 | A grant is being offered downstream |
| out_prio_o | output | 4 | Priority of the granted port |
| out_port_o | output | IDX_W | Index of the granted port |

## Verification
The recency list and the hold lock both feed the grant combinationally. A corrupted order entry or a stale lock therefore shows up as a wrong `gnt_o` on the first cycle in which a tie among top-priority ports, or a stalled handshake, exercises that entry. A reference model keeps last-grant timestamps instead of an ordered list and predicts every cycle's grant, priority and index. It runs over random traffic and over directed ties, stalls, withdrawals and priority changes. A recency update on a non-accepted grant appears as a wrong winner at the next tie between the affected ports.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  localparam int unsigned PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/qos_lrg_order.sv
// Ordered recency list: position 0 holds the least recently granted port.
module qos_lrg_order #(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                upd_i,
  input  logic [IDX_W-1:0]                    upd_idx_i,
  output logic [NUM_PORTS-1:0][IDX_W-1:0]     order_o
);
  logic [NUM_PORTS-1:0][IDX_W-1:0] order_q, order_d;

  // Move the granted port to the most-recent end; close the gap behind it.
  always_comb begin
    logic found;
    found   = 1'b0;
    order_d = order_q;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (order_q[k] == upd_idx_i) found = 1'b1;
      if (found && (k < NUM_PORTS - 1)) order_d[k] = order_q[k+1];
    end
    order_d[NUM_PORTS-1] = upd_idx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PORTS; k++) order_q[k] <= IDX_W'(k);
    end else if (upd_i) begin
      order_q <= order_d;
    end
  end

  assign order_o = order_q;

  // The list changes only on a completed handshake.
  assert_order_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(order_q));

  // Each port index appears exactly once in the list.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_perm
    logic [NUM_PORTS-1:0] hit;
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_hit
      assign hit[k] = (order_q[k] == IDX_W'(p));
    end
    assert_order_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) == 1);
  end
endmodule

// File: rtl/qos_lrg_pick.sv
// Combinational choice: highest priority first, then the oldest entry in the list.
module qos_lrg_pick
  import qos_arb_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PORTS-1:0]            valid_i,
  input  prio_t [NUM_PORTS-1:0]           prio_i,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] order_i,
  output logic                            win_valid_o,
  output logic [IDX_W-1:0]                win_idx_o
);
  prio_t top_prio;

  always_comb begin
    top_prio = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (valid_i[p] && (prio_i[p] > top_prio)) top_prio = prio_i[p];
    end
  end

  always_comb begin
    logic found;
    found     = 1'b0;
    win_idx_o = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (!found && valid_i[order_i[k]] && (prio_i[order_i[k]] == top_prio)) begin
        found     = 1'b1;
        win_idx_o = order_i[k];
      end
    end
  end

  assign win_valid_o = |valid_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_top_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> !(valid_i[p] && (prio_i[p] > prio_i[win_idx_o])));
  end
endmodule

// File: rtl/qos_lrg_arbiter.sv
module qos_lrg_arbiter
  import qos_arb_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  localparam int unsigned IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        req_valid_i,
  input  logic [NUM_PORTS*PRIO_W-1:0] req_prio_i,
  input  logic                        out_ready_i,
  output logic [NUM_PORTS-1:0]        gnt_o,
  output logic                        out_valid_o,
  output logic [PRIO_W-1:0]           out_prio_o,
  output logic [IDX_W-1:0]            out_port_o
);
  prio_t [NUM_PORTS-1:0]           prio_vec;
  logic  [NUM_PORTS-1:0][IDX_W-1:0] order;
  logic                             pick_valid;
  logic  [IDX_W-1:0]                pick_idx;
  logic                             lock_q, lock_d;
  logic  [IDX_W-1:0]                lock_idx_q, lock_idx_d;
  logic                             lock_live, sel_any, hs;
  logic  [IDX_W-1:0]                sel_idx;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack
    assign prio_vec[p] = req_prio_i[p*PRIO_W +: PRIO_W];
  end

  qos_lrg_order #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (hs),
    .upd_idx_i (sel_idx),
    .order_o   (order)
  );

  qos_lrg_pick #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (req_valid_i),
    .prio_i      (prio_vec),
    .order_i     (order),
    .win_valid_o (pick_valid),
    .win_idx_o   (pick_idx)
  );

  // A stalled grant stays put while its requester keeps asking.
  assign lock_live = lock_q && req_valid_i[lock_idx_q];
  assign sel_idx   = lock_live ? lock_idx_q : pick_idx;
  assign sel_any   = lock_live || pick_valid;
  assign hs        = sel_any && out_ready_i;

  always_comb begin
    gnt_o = '0;
    if (sel_any) gnt_o[sel_idx] = 1'b1;
  end

  assign out_valid_o = sel_any;
  assign out_prio_o  = prio_vec[sel_idx];
  assign out_port_o  = sel_idx;

  always_comb begin
    lock_d     = sel_any && !out_ready_i;
    lock_idx_d = sel_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q <= lock_d;
      if (lock_d) lock_idx_q <= lock_idx_d;
    end
  end

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o) && ((|gnt_o) == (|req_valid_i)));

  assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (!(|($past(gnt_o) & req_valid_i)) || (gnt_o == $past(gnt_o))));
endmodule

// File: tb/qos_lrg_arbiter_test.sv
`timescale 1ns/1ps
module qos_lrg_arbiter_test;
  localparam int N = 5;
  localparam int IW = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   req_valid_i;
  logic [N*4-1:0] req_prio_i;
  logic           out_ready_i;
  logic [N-1:0]   gnt_o;
  logic           out_valid_o;
  logic [3:0]     out_prio_o;
  logic [IW-1:0]  out_port_o;

  qos_lrg_arbiter #(.NUM_PORTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_prio_i(req_prio_i),
    .out_ready_i(out_ready_i), .gnt_o(gnt_o), .out_valid_o(out_valid_o),
    .out_prio_o(out_prio_o), .out_port_o(out_port_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference state: last-grant timestamps, pending requests, stall lock.
  int       stamp [N];
  int       tnow;
  bit       pend [N];
  int       pprio [N];
  bit       lock_m;
  int       lock_idx_m;

  task automatic check(string tag, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_pick(output string tag);
    int best, top, ties;
    best = -1; top = -1; ties = 0;
    if (lock_m && pend[lock_idx_m]) begin tag = "R6"; return lock_idx_m; end
    for (int p = 0; p < N; p++) if (pend[p] && pprio[p] > top) top = pprio[p];
    for (int p = 0; p < N; p++) begin
      if (pend[p] && pprio[p] == top) begin
        ties++;
        if (best < 0 || stamp[p] < stamp[best]) best = p;
      end
    end
    tag = (ties > 1) ? "R2" : "R1";
    return best;
  endfunction

  // One cycle: drive at negedge, check 1 ns later, update model, pass posedge.
  task automatic cycle(bit rdy, string force_tag);
    int exp; string tag; logic [N-1:0] eg;
    @(negedge clk);
    for (int p = 0; p < N; p++) begin
      req_valid_i[p] = pend[p];
      req_prio_i[p*4 +: 4] = pprio[p][3:0];
    end
    out_ready_i = rdy;
    #1;
    exp = model_pick(tag);
    if (force_tag != "") tag = force_tag;
    eg = '0;
    if (exp >= 0) eg[exp] = 1'b1;
    check((exp >= 0) ? tag : "R5", gnt_o == eg, int'(gnt_o), int'(eg));
    check("R5", out_valid_o == (exp >= 0), int'(out_valid_o), int'(exp >= 0));
    if (exp >= 0) begin
      check("R4", out_prio_o == pprio[exp][3:0], int'(out_prio_o), pprio[exp]);
      check("R4", int'(out_port_o) == exp, int'(out_port_o), exp);
      if (rdy) begin
        stamp[exp] = tnow++; pend[exp] = 0; lock_m = 0;
      end else begin
        lock_m = 1; lock_idx_m = exp;
      end
    end else lock_m = 0;
  endtask

  task automatic set_req(int p, int pr);
    pend[p] = 1; pprio[p] = pr;
  endtask

  task automatic clear_all();
    for (int p = 0; p < N; p++) pend[p] = 0;
  endtask

  initial begin
    for (int p = 0; p < N; p++) begin stamp[p] = p; pend[p] = 0; pprio[p] = 0; end
    tnow = N; lock_m = 0; lock_idx_m = 0;
    rst_n = 0; req_valid_i = '0; req_prio_i = '0; out_ready_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // Reset state, no requests: no grant (R5).
    cycle(1, "R5");

    // R8: all ports equal, stalled; port 0 is least recent after reset.
    for (int p = 0; p < N; p++) set_req(p, 3);
    cycle(0, "R8");
    cycle(0, "R6");
    // R3: equal priorities rotate in least-recently-granted order.
    for (int i = 0; i < N; i++) cycle(1, "R3");
    for (int p = 0; p < N; p++) set_req(p, 7);
    for (int i = 0; i < N; i++) cycle(1, "R3");

    // R6: stalled low-priority grant survives a higher arrival.
    set_req(1, 2);
    cycle(0, "R6");
    set_req(3, 9);
    cycle(0, "R6");
    cycle(0, "R6");
    cycle(1, "R6");
    cycle(1, "R1");

    // R7: grant withdrawn before acceptance leaves recency untouched.
    set_req(2, 5);
    cycle(0, "R7");
    clear_all();
    cycle(0, "R7");
    set_req(2, 5); set_req(4, 5);
    cycle(1, "R7");
    cycle(1, "R7");

    // R9: same port changes priority between transactions.
    set_req(0, 1); set_req(1, 4);
    cycle(1, "R9");
    set_req(0, 12);
    cycle(1, "R9");
    cycle(1, "R9");

    // R1: single requester at priority 0 and contenders at extremes.
    set_req(4, 0);
    cycle(1, "R1");
    set_req(0, 0); set_req(2, 15);
    cycle(1, "R1");
    cycle(1, "R2");

    // Constrained random traffic.
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int mode;
      mode = i / 1000;
      for (int p = 0; p < N; p++) begin
        if (!pend[p] && ($urandom % 4) != 0) begin
          if (mode == 1) set_req(p, 6);
          else if (mode == 2) set_req(p, ($urandom % 2) ? 15 : 14);
          else set_req(p, $urandom % 16);
        end
      end
      if (mode == 3 && ($urandom % 8) == 0) clear_all();
      cycle(($urandom % 3) != 0, "");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule